// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block is a register-mapped station manager for Clause 45 MDIO devices. Software first loads a 16-bit target register number into the address register. It then writes the management register with a port number, a device number and an operation code. A valid code starts a command. Each command sends an address frame that carries the stored register number, then a second frame that either writes the 16-bit data field or reads 16 bits back from the device.

The management register shows whether a command is running and whether a read has returned data. The MDC clock runs continuously. A two-bit code in the configuration register divides the system clock by 256, 64, 32 or 8 to produce it. The master changes MDIO after a falling MDC edge. During a read it releases the line from the turnaround onward and samples the device's bits on rising MDC edges.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, MDC is low, the MDIO driver is off, and the management, address and configuration registers all read as zero.
- R2: A write to offset 0x0 while idle starts a command only when bits [28:26] hold 5 (write) or 7 (read). Busy (bit 30) is set in the next cycle. Any other code leaves busy clear and leaves the register contents unchanged.
- R3: Every command first sends an address frame, most significant bit first: 32 preamble ones, start 00, op 00, the 5-bit port field from bits [20:16], the 5-bit device field from bits [25:21], turnaround 10, and the 16-bit value of the address register. Every bit of this frame is driven, and MDIO is never driven while idle.
- R4: A write command's second frame is preamble, 00, op 01, port, device, 10 and the data from bits [15:0], with all bits driven.
- R5: A read command's second frame drives preamble, 00, op 11, port and device, then releases MDIO for the two turnaround bits and the 16 data bits. The 16 bits sampled on rising MDC edges, MSB first, appear in bits [15:0] with read-valid (bit 29) set.
- R6: Busy stays set for all 128 MDC periods of the two frames. It clears on the falling MDC edge that ends the last data bit.
- R7: Read-valid clears when a command is accepted, and a write command leaves it clear.
- R8: A management write made while busy is ignored: the frames in flight and the stored port, device and code do not change.
- R9: Divider code 0, 1, 2 or 3 in configuration bits [1:0] gives an MDC period of 256, 64, 32 or 8 system clocks, high for half of that period.
- R10: All 32 configuration bits read back as written, and the divider code resets to 0.
- R11: A new divider code takes effect only at an MDC period boundary while no command is busy, so a frame keeps its MDC period from start to end.
- R12: The address register at offset 0x8 keeps bits [15:0] of the written word and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset (0x0, 0x8, 0xC) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A wrong bit counter or phase flag shows up at the MDIO pins within one MDC period: a frame comes out with the wrong op field, the wrong length or a badly placed turnaround. Busy then also clears a whole number of MDC periods too early or too late. A wrong divider state shows up as a wrong MDC period or duty cycle within a single MDC cycle. A wrong capture state only becomes visible when the read ends, as a wrong data word or a wrong read-valid bit in the management register.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    localparam int MD_DATA_W = 16;
    localparam int MD_PORT_W = 5;
    localparam int MD_DEV_W  = 5;
    localparam int MD_OPC_W  = 3;
    localparam int MD_CNT_W  = 8;

    localparam logic [MD_OPC_W-1:0] OPC_WRITE = 3'd5;
    localparam logic [MD_OPC_W-1:0] OPC_READ  = 3'd7;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_XFER = 2'd2
    } eng_state_e;

    // last count value of one MDC period for each divider code
    function automatic logic [MD_CNT_W-1:0] div_last(input logic [1:0] code);
        case (code)
            2'd0:    div_last = 8'd255;
            2'd1:    div_last = 8'd63;
            2'd2:    div_last = 8'd31;
            default: div_last = 8'd7;
        endcase
    endfunction

    // count value after which MDC goes high
    function automatic logic [MD_CNT_W-1:0] div_half_m1(input logic [1:0] code);
        case (code)
            2'd0:    div_half_m1 = 8'd127;
            2'd1:    div_half_m1 = 8'd31;
            2'd2:    div_half_m1 = 8'd15;
            default: div_half_m1 = 8'd3;
        endcase
    endfunction

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen
    import mdio_c45_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_code,
    input  logic       hold,
    output logic       mdc,
    output logic       rise_evt,
    output logic       fall_evt,
    output logic [1:0] active_code
);

    typedef struct packed {
        logic [MD_CNT_W-1:0] cnt;
        logic                mdc;
        logic [1:0]          code;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_evt = (st_q.cnt == div_half_m1(st_q.code));
        fall_evt = (st_q.cnt == div_last(st_q.code));
        if (fall_evt) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
            if (!hold) begin
                st_d.code = div_code;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (rise_evt) begin
                st_d.mdc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc         = st_q.mdc;
    assign active_code = st_q.code;

endmodule

// File: rtl/mdio_c45_frame.sv
module mdio_c45_frame
    import mdio_c45_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_read,
    input  logic [MD_PORT_W-1:0] port,
    input  logic [MD_DEV_W-1:0]  dev,
    input  logic [MD_DATA_W-1:0] addr_in,
    input  logic [MD_DATA_W-1:0] wdata,
    input  logic                 rise_evt,
    input  logic                 fall_evt,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 rd_done,
    output logic [MD_DATA_W-1:0] rd_word
);

    localparam int FRAME_BITS = PRE_LEN + 4 + MD_PORT_W + MD_DEV_W + 2 + MD_DATA_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(FRAME_BITS - MD_DATA_W - 2);
    localparam logic [BIT_W-1:0] DAT_BIT  = BIT_W'(FRAME_BITS - MD_DATA_W);

    typedef struct packed {
        eng_state_e           st;
        logic                 phase;
        logic [BIT_W-1:0]     bitn;
        logic [MD_DATA_W-1:0] addr;
        logic [MD_DATA_W-1:0] rsh;
    } eng_state_t;

    eng_state_t eng_d, eng_q;

    logic [1:0]            op_code;
    logic [MD_DATA_W-1:0]  payload;
    logic [FRAME_BITS-1:0] frame_vec;
    logic [BIT_W-1:0]      sel;
    logic                  in_xfer;
    logic                  data_rd;

    always_comb begin
        eng_d   = eng_q;
        rd_done = 1'b0;

        op_code   = !eng_q.phase ? 2'b00 : (is_read ? 2'b11 : 2'b01);
        payload   = eng_q.phase ? wdata : eng_q.addr;
        frame_vec = {{PRE_LEN{1'b1}}, 2'b00, op_code, port, dev, 2'b10, payload};
        sel       = LAST_BIT - eng_q.bitn;
        in_xfer   = (eng_q.st == ENG_XFER);
        data_rd   = in_xfer && eng_q.phase && is_read;
        mdio_oe   = in_xfer && !(data_rd && (eng_q.bitn >= TA_BIT));
        mdio_o    = in_xfer && frame_vec[sel];

        case (eng_q.st)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.st   = ENG_WAIT;
                    eng_d.addr = addr_in;
                end
            end
            ENG_WAIT: begin
                if (fall_evt) begin
                    eng_d.st    = ENG_XFER;
                    eng_d.phase = 1'b0;
                    eng_d.bitn  = '0;
                end
            end
            ENG_XFER: begin
                if (rise_evt && data_rd && (eng_q.bitn >= DAT_BIT)) begin
                    eng_d.rsh = {eng_q.rsh[MD_DATA_W-2:0], mdio_i};
                end
                if (fall_evt) begin
                    if (eng_q.bitn == LAST_BIT) begin
                        eng_d.bitn = '0;
                        if (!eng_q.phase) begin
                            eng_d.phase = 1'b1;
                        end else begin
                            eng_d.st = ENG_IDLE;
                            rd_done  = is_read;
                        end
                    end else begin
                        eng_d.bitn = eng_q.bitn + 1'b1;
                    end
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, phase: 1'b0, bitn: '0, addr: '0, rsh: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy    = (eng_q.st != ENG_IDLE);
    assign rd_word = eng_q.rsh;

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam logic [ADDR_W-1:0] OFS_MGMT = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'hC);

    typedef struct packed {
        logic [MD_PORT_W-1:0] port;
        logic [MD_DEV_W-1:0]  dev;
        logic [MD_OPC_W-1:0]  opc;
        logic [MD_DATA_W-1:0] data;
        logic                 rvalid;
        logic [MD_DATA_W-1:0] addr;
        logic [31:0]          cfg;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                 busy;
    logic                 rise_evt;
    logic                 fall_evt;
    logic                 rd_done;
    logic [MD_DATA_W-1:0] rd_word;
    logic [1:0]           act_code;
    logic [MD_OPC_W-1:0]  opc_in;
    logic                 start;
    logic                 rvalid_w;
    logic [MD_PORT_W-1:0] port_w;

    always_comb begin
        rg_d   = rg_q;
        opc_in = reg_wdata[28:26];
        start  = reg_wen && (reg_addr == OFS_MGMT) && !busy &&
                 ((opc_in == OPC_WRITE) || (opc_in == OPC_READ));

        if (start) begin
            rg_d.port   = reg_wdata[20:16];
            rg_d.dev    = reg_wdata[25:21];
            rg_d.opc    = opc_in;
            rg_d.data   = reg_wdata[15:0];
            rg_d.rvalid = 1'b0;
        end
        if (reg_wen && (reg_addr == OFS_ADDR)) begin
            rg_d.addr = reg_wdata[15:0];
        end
        if (reg_wen && (reg_addr == OFS_CFG)) begin
            rg_d.cfg = reg_wdata;
        end
        if (rd_done) begin
            rg_d.data   = rd_word;
            rg_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_MGMT: reg_rdata = {1'b0, busy, rg_q.rvalid, rg_q.opc, rg_q.dev, rg_q.port, rg_q.data};
            OFS_ADDR: reg_rdata = {16'h0000, rg_q.addr};
            OFS_CFG:  reg_rdata = rg_q.cfg;
            default:  reg_rdata = '0;
        endcase
    end

    assign rvalid_w = rg_q.rvalid;
    assign port_w   = rg_q.port;

    mdio_c45_clkgen u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_code    (rg_q.cfg[1:0]),
        .hold        (busy),
        .mdc         (mdc),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .active_code (act_code)
    );

    mdio_c45_frame #(
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_read  (rg_q.opc == OPC_READ),
        .port     (rg_q.port),
        .dev      (rg_q.dev),
        .addr_in  (rg_q.addr),
        .wdata    (rg_q.data),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_word  (rd_word)
    );

endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              rvalid,
    input logic              mdc,
    input logic              mdio_oe,
    input logic [4:0]        cmd_port,
    input logic [1:0]        act_code
);

    logic mgmt_wr;
    logic good_opc;
    assign mgmt_wr  = reg_wen && (reg_addr == '0);
    assign good_opc = (reg_wdata[28:26] == 3'd5) || (reg_wdata[28:26] == 3'd7);

    // R2 R7
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !busy && good_opc) |=> (busy && !rvalid));

    // R2
    bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !busy && !good_opc) |=> !busy);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && busy) |=> $stable(cmd_port));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mdc) && !mdc));

    // R11
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_code));

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

endmodule

bind mdio_c45_master mdio_c45_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .rvalid    (rvalid_w),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .cmd_port  (port_w),
    .act_code  (act_code)
);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    always #2 clk = ~clk;

    mdio_c45_master u_mdio_c45_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;

    always @(negedge clk) cyc++;

    // frame monitor: counts MDC rises of one command, from its first driven bit
    logic        cap_o  [0:127];
    logic        cap_oe [0:127];
    logic        cap_bz [0:127];
    int          n = 0;
    bit          on = 0;
    int          cmd_id = 0;
    int          seen_id = 0;
    bit          arm = 0;
    logic [15:0] phy_word = 16'h0;

    always @(posedge mdc) begin
        if (seen_id != cmd_id) begin
            seen_id = cmd_id;
            n = 0;
            on = 0;
        end
        if (arm && (on || mdio_oe)) begin
            on = 1;
            if (n < 128) begin
                cap_o[n]  = mdio_o;
                cap_oe[n] = mdio_oe;
                cap_bz[n] = reg_rdata[30];
            end
            n++;
        end
    end

    // device model: drives the read data after falling MDC, bit for rise n
    always @(negedge mdc) begin
        if (on && seen_id == cmd_id && n >= 112 && n < 128) mdio_i = phy_word[127 - n];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = 4'h0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 4'h0;
    endtask

    task automatic measure(output int per, output int hi);
        int t0, t1;
        @(posedge mdc); t0 = cyc;
        @(negedge mdc); t1 = cyc;
        @(posedge mdc);
        per = cyc - t0;
        hi  = t1 - t0;
    endtask

    function automatic logic [63:0] frame(input logic [1:0] op, input logic [4:0] p,
                                          input logic [4:0] d, input logic [15:0] pl);
        return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, pl};
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // intrude: 0 none, 1 second command while busy, 2 divider change while busy
    task automatic run_cmd(input bit rd, input logic [4:0] p, input logic [4:0] d,
                           input logic [15:0] a, input logic [15:0] v, input int intrude);
        logic [31:0] r;
        logic [63:0] g1, g2, e1, e2, o1, o2, m2;
        logic [2:0]  opc;
        int per, hi;
        bit done;
        opc = rd ? 3'd7 : 3'd5;
        reg_write(4'h8, {16'h0, a});
        phy_word = v;
        cmd_id++;
        arm = 1;
        reg_write(4'h0, {3'b000, opc, d, p, rd ? 16'h0000 : v});
        reg_read(4'h0, r);
        chk("R2", "busy after accept", {63'd0, r[30]}, 64'd1);
        chk("R7", "read-valid after accept", {63'd0, r[29]}, 64'd0);
        if (intrude == 1) begin
            repeat (100) @(negedge clk);
            reg_write(4'h0, {3'b000, 3'd7, 5'h11, 5'h1C, 16'h7777});
        end
        if (intrude == 2) begin
            repeat (50) @(negedge clk);
            reg_write(4'hC, 32'h0000_0002);
            measure(per, hi);
            measure(per, hi);
            chk("R11", "MDC period while busy", 64'(per), 64'd8);
        end
        done = 0;
        for (int k = 0; k < 60000; k++) begin
            @(negedge clk);
            if (!reg_rdata[30]) begin done = 1; break; end
        end
        arm = 0;
        chk("R6", "busy cleared", {63'd0, done}, 64'd1);
        chk("R6", "MDC periods while busy", 64'(n), 64'd128);
        chk("R6", "busy at last data bit", {63'd0, cap_bz[127]}, 64'd1);
        for (int i = 0; i < 64; i++) begin
            g1[63 - i] = cap_o[i];
            o1[63 - i] = cap_oe[i];
            g2[63 - i] = cap_o[64 + i];
            o2[63 - i] = cap_oe[64 + i];
        end
        e1 = frame(2'b00, p, d, a);
        chk("R3", "address frame bits", g1, e1);
        chk("R3", "address frame drive", o1, 64'hFFFF_FFFF_FFFF_FFFF);
        if (rd) begin
            m2 = 64'hFFFF_FFFF_FFFC_0000;
            e2 = frame(2'b11, p, d, 16'h0000);
            chk("R5", "read frame bits", g2 & m2, e2 & m2);
            chk("R5", "read frame drive", o2, m2);
        end else begin
            e2 = frame(2'b01, p, d, v);
            chk("R4", "write frame bits", g2, e2);
            chk("R4", "write frame drive", o2, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        reg_read(4'h0, r);
        chk(rd ? "R5" : "R7", "management readback", 64'(r),
            64'({1'b0, 1'b0, rd, opc, d, p, v}));
    endtask

    initial begin
        logic [31:0] r, m0;
        int per, hi;
        int ratio;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "mdc after reset", {63'd0, mdc}, 64'd0);
        chk("R1", "mdio_oe after reset", {63'd0, mdio_oe}, 64'd0);
        reg_read(4'h0, r); chk("R1", "management reset", 64'(r), 64'd0);
        reg_read(4'h8, r); chk("R1", "address reset", 64'(r), 64'd0);
        reg_read(4'hC, r); chk("R1", "config reset", 64'(r), 64'd0);

        // R9 divider sweep
        for (int c = 0; c < 4; c++) begin
            ratio = (c == 0) ? 256 : (c == 1) ? 64 : (c == 2) ? 32 : 8;
            reg_write(4'hC, 32'(c));
            measure(per, hi);
            measure(per, hi);
            chk("R9", $sformatf("period code %0d", c), 64'(per), 64'(ratio));
            chk("R9", $sformatf("high time code %0d", c), 64'(hi), 64'(ratio / 2));
        end

        // R10 config readback of all bits
        reg_write(4'hC, 32'hA5A5_5A5B);
        reg_read(4'hC, r);
        chk("R10", "config readback", 64'(r), 64'hA5A5_5A5B);
        measure(per, hi);
        measure(per, hi);
        chk("R10", "code field with upper bits set", 64'(per), 64'd8);

        // R12 address register width
        reg_write(4'h8, 32'hFFFF_BEEF);
        reg_read(4'h8, r);
        chk("R12", "address readback", 64'(r), 64'h0000_BEEF);

        // R2 invalid opcodes are ignored
        reg_read(4'h0, m0);
        for (int o = 0; o < 7; o++) begin
            if (o == 5) continue;
            reg_write(4'h0, {3'b000, 3'(o), 5'h1F, 5'h1F, 16'hFFFF});
            repeat (3) @(negedge clk);
            chk("R2", $sformatf("mdio_oe opcode %0d", o), {63'd0, mdio_oe}, 64'd0);
            reg_read(4'h0, r);
            chk("R2", $sformatf("ignored opcode %0d", o), 64'(r), 64'(m0));
        end

        // R3 R4 writes over field patterns
        run_cmd(0, 5'h00, 5'h00, 16'h0000, 16'h0000, 0);
        run_cmd(0, 5'h1F, 5'h1F, 16'hFFFF, 16'hFFFF, 0);
        run_cmd(0, 5'h0A, 5'h15, 16'hA5A5, 16'h5A5A, 0);
        run_cmd(0, 5'h13, 5'h04, 16'h1234, 16'h8001, 0);
        // R5 reads
        run_cmd(1, 5'h05, 5'h01, 16'h0002, 16'hC3A5, 0);
        run_cmd(1, 5'h1E, 5'h1F, 16'hFFFF, 16'hFFFF, 0);
        run_cmd(1, 5'h00, 5'h03, 16'h8000, 16'h0001, 0);
        // R7 write after a completed read clears read-valid (checked in run_cmd)
        run_cmd(0, 5'h01, 5'h02, 16'h0F0F, 16'h3C3C, 0);
        // R8 command written while busy
        run_cmd(0, 5'h02, 5'h06, 16'h0F0F, 16'h3C3C, 1);
        // R11 divider change while busy
        run_cmd(0, 5'h07, 5'h09, 16'h4455, 16'h6677, 2);
        repeat (300) @(negedge clk);
        measure(per, hi);
        measure(per, hi);
        chk("R11", "new divider after idle", 64'(per), 64'd32);
        run_cmd(1, 5'h09, 5'h0C, 16'h4321, 16'h9E37, 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule